// File: doc/BRIEF.md
# Trigger primitive evaluator

This block turns each captured 32-bit sample into a set of trigger condition bits for a logic-analyzer trigger path. It evaluates a bank of primitives side by side on every sample: ten masked-value match terms, two inclusive unsigned range detectors, two edge detectors with a 2-bit edge-type selection per channel, and two countdown timers. Each primitive yields one registered bit, and a downstream combiner and sequencer consume those bits. No primitive needs a second pass over the data.

Configuration arrives through a write-only register port (address, data, write enable): match targets and masks, range bounds, edge-type codes and timer reload values. The sequencer drives the timers with start, stop and clear strobes, one bit per timer. Each timer is a four-state machine. The states are IDLE (stopped, count zero), RUN (counting), HALT (paused, count held) and DONE (expired, output high). The transitions are: *launch* IDLE→RUN on start; *pause* RUN→HALT on stop; *resume* HALT→RUN on start; *expire* RUN→DONE when the count equals the reload value; and *flush*, from any state to IDLE on clear.

Top module: `trig_prim_eval`

## Requirements
- R1: One cycle after a valid sample, hit_match[k] is 1 exactly when ((sample XOR target_k) AND mask_k) is zero. A term whose mask is zero always matches.
- R2: The ten match terms are independent. target_k is written at address k (0..9) and mask_k at address 16+k. Writes to addresses outside the map (42..63 and the gaps 10..15, 26..31) change nothing.
- R3: hit_range[r] is 1 when lower_r <= sample <= upper_r, compared unsigned with both bounds inclusive. lower_r is at address 32+r and upper_r at address 34+r. When lower_r > upper_r the bit is never set.
- R4: Edge detector e takes a 64-bit code. Bits 2c and 2c+1 belong to channel c. Channels 0..15 are written at address 36+2e and channels 16..31 at 37+2e. Code 00 means no change, 01 rising, 10 falling and 11 either edge. An unchanged channel never produces an event.
- R5: hit_edge[e] is the OR of the events on channels whose code is not 00. Channels with code 00 are don't-care.
- R6: An edge compares the sample with the previous valid sample. The first valid sample after reset produces no edge.
- R7: All primitive outputs except the timers update only on the clock edge that samples smp_valid high, and hold otherwise. A cycle without smp_valid does not change the stored previous sample.
- R8: Timer t's reload value is at address 40+t. After start is sampled in IDLE, hit_timer[t] rises exactly L+1 cycles later, where L is the reload value.
- R9: Once high, hit_timer[t] stays high until clear. Stop pauses a running count, and start resumes it from the held value. Stop takes priority over start.
- R10: Clear takes priority over start and stop. It returns the timer to IDLE with count zero, and its output is 0 on the next cycle.
- R11: After reset all outputs are 0 and all configuration registers are 0.
- R12: A configuration write and a valid sample in the same cycle evaluate the sample against the configuration as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 32 | Sample word, one bit per channel |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| tmr_start | input | 2 | Start or resume strobe per timer |
| tmr_stop | input | 2 | Pause strobe per timer |
| tmr_clear | input | 2 | Clear strobe per timer |
| hit_match | output | 10 | Match term results |
| hit_range | output | 2 | Range detector results |
| hit_edge | output | 2 | Edge detector results |
| hit_timer | output | 2 | Timer expired flags |

## Verification
A configuration write and a sample evaluation can fall in the same cycle, and the sample must then be judged against the old values. The bench provokes this directly: it rewrites a match target in the cycle that carries the matching sample. The random phase then adds register writes on about a quarter of the sample cycles. The bench's reference model computes each expected result before it applies that cycle's write, so any leak of new configuration into the current sample shows up as a mismatch. Clear against start on the same timer is a second collision, and the bench drives both strobes in one cycle and expects the output to stay low.

// File: rtl/trig_prim_pkg.sv
package trig_prim_pkg;

    localparam int SMP_W     = 32;
    localparam int NUM_MATCH = 10;
    localparam int NUM_RANGE = 2;
    localparam int NUM_EDGE  = 2;
    localparam int NUM_TMR   = 2;
    localparam int CFG_AW    = 6;
    localparam int TMR_W     = 32;

    // register map; only the relative layout matters to the decoder
    localparam int ADR_TGT  = 0;
    localparam int ADR_MSK  = 16;
    localparam int ADR_LO   = 32;
    localparam int ADR_HI   = ADR_LO + NUM_RANGE;
    localparam int ADR_EDGE = ADR_HI + NUM_RANGE;
    localparam int ADR_LOAD = ADR_EDGE + 2 * NUM_EDGE;

    // per-channel edge selection: bit 0 rising, bit 1 falling
    localparam logic [1:0] EC_NONE = 2'b00;
    localparam logic [1:0] EC_RISE = 2'b01;
    localparam logic [1:0] EC_FALL = 2'b10;
    localparam logic [1:0] EC_ANY  = 2'b11;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_RUN  = 2'd1,
        T_HALT = 2'd2,
        T_DONE = 2'd3
    } tmr_state_e;

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_prim_pkg::*;
#(
    parameter int DW = SMP_W,
    parameter int NM = NUM_MATCH,
    parameter int NR = NUM_RANGE,
    parameter int NE = NUM_EDGE,
    parameter int NT = NUM_TMR,
    parameter int AW = CFG_AW,
    parameter int TW = TMR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [AW-1:0]               cfg_addr,
    input  logic [DW-1:0]               cfg_wdata,
    output logic [NM-1:0][DW-1:0]       tgt,
    output logic [NM-1:0][DW-1:0]       msk,
    output logic [NR-1:0][DW-1:0]       lo,
    output logic [NR-1:0][DW-1:0]       hi,
    output logic [NE-1:0][2*DW-1:0]     ecode,
    output logic [NT-1:0][TW-1:0]       load
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt   <= '0;
            msk   <= '0;
            lo    <= '0;
            hi    <= '0;
            ecode <= '0;
            load  <= '0;
        end else if (cfg_we) begin
            for (int k = 0; k < NM; k++) begin
                if (cfg_addr == AW'(ADR_TGT + k)) tgt[k] <= cfg_wdata;
                if (cfg_addr == AW'(ADR_MSK + k)) msk[k] <= cfg_wdata;
            end
            for (int r = 0; r < NR; r++) begin
                if (cfg_addr == AW'(ADR_LO + r)) lo[r] <= cfg_wdata;
                if (cfg_addr == AW'(ADR_HI + r)) hi[r] <= cfg_wdata;
            end
            for (int e = 0; e < NE; e++) begin
                for (int h = 0; h < 2; h++) begin
                    if (cfg_addr == AW'(ADR_EDGE + 2 * e + h))
                        ecode[e][h*DW +: DW] <= cfg_wdata;
                end
            end
            for (int t = 0; t < NT; t++) begin
                if (cfg_addr == AW'(ADR_LOAD + t)) load[t] <= TW'(cfg_wdata);
            end
        end
    end

    AST_CFG_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tgt == '0 && msk == '0 && load == '0)); // R11

endmodule

// File: rtl/trig_cmp_bank.sv
module trig_cmp_bank
    import trig_prim_pkg::*;
#(
    parameter int DW = SMP_W,
    parameter int NM = NUM_MATCH,
    parameter int NR = NUM_RANGE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic [DW-1:0]         smp_data,
    input  logic [NM-1:0][DW-1:0] tgt,
    input  logic [NM-1:0][DW-1:0] msk,
    input  logic [NR-1:0][DW-1:0] lo,
    input  logic [NR-1:0][DW-1:0] hi,
    output logic [NM-1:0]         hit_match,
    output logic [NR-1:0]         hit_range
);

    logic [NM-1:0] match_c;
    logic [NR-1:0] range_c;

    generate
        for (genvar k = 0; k < NM; k++) begin : g_match
            assign match_c[k] = ~|((smp_data ^ tgt[k]) & msk[k]);
        end
        for (genvar r = 0; r < NR; r++) begin : g_range
            assign range_c[r] = (smp_data >= lo[r]) && (smp_data <= hi[r]);

            AST_RANGE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
                (smp_valid && (lo[r] > hi[r])) |=> !hit_range[r]); // R3
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_match <= '0;
            hit_range <= '0;
        end else if (smp_valid) begin
            hit_match <= match_c;
            hit_range <= range_c;
        end
    end

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(hit_match) && $stable(hit_range))); // R7

    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && msk[0] == '0) |=> hit_match[0]); // R1

endmodule

// File: rtl/trig_edge_bank.sv
module trig_edge_bank
    import trig_prim_pkg::*;
#(
    parameter int DW = SMP_W,
    parameter int NE = NUM_EDGE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [DW-1:0]           smp_data,
    input  logic [NE-1:0][2*DW-1:0] ecode,
    output logic [NE-1:0]           hit_edge
);

    logic [DW-1:0] prev_q;
    logic          prev_ok;
    logic [DW-1:0] rise_c;
    logic [DW-1:0] fall_c;
    logic [NE-1:0] event_c;

    assign rise_c = smp_data & ~prev_q & {DW{prev_ok}};
    assign fall_c = ~smp_data & prev_q & {DW{prev_ok}};

    always_comb begin
        for (int e = 0; e < NE; e++) begin
            event_c[e] = 1'b0;
            for (int c = 0; c < DW; c++) begin
                event_c[e] = event_c[e]
                           | (ecode[e][2*c]   & rise_c[c])
                           | (ecode[e][2*c+1] & fall_c[c]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            prev_ok  <= 1'b0;
            hit_edge <= '0;
        end else if (smp_valid) begin
            prev_q   <= smp_data;
            prev_ok  <= 1'b1;
            hit_edge <= event_c;
        end
    end

    AST_EDGE_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !prev_ok) |=> (hit_edge == '0)); // R6

    AST_EDGE_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && prev_ok && smp_data == prev_q) |=> (hit_edge == '0)); // R4

    generate
        for (genvar e = 0; e < NE; e++) begin : g_chk
            AST_EDGE_ALL_DONTCARE: assert property (@(posedge clk) disable iff (!rst_n)
                (smp_valid && ecode[e] == '0) |=> !hit_edge[e]); // R5
        end
    endgenerate

endmodule

// File: rtl/trig_timer.sv
module trig_timer
    import trig_prim_pkg::*;
#(
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] load,
    input  logic          start,
    input  logic          stop,
    input  logic          clear,
    output logic          hit
);

    tmr_state_e    st_q;
    tmr_state_e    st_nxt;
    logic [TW-1:0] cnt_q;

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        if (clear) begin
            st_nxt = T_IDLE;                        // flush
        end else begin
            unique case (st_q)
                T_IDLE: if (start) st_nxt = T_RUN;  // launch
                T_RUN: begin
                    if (stop)               st_nxt = T_HALT;  // pause
                    else if (cnt_q == load) st_nxt = T_DONE;  // expire
                end
                T_HALT: if (start && !stop) st_nxt = T_RUN;   // resume
                T_DONE: st_nxt = T_DONE;
                default: st_nxt = T_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= T_IDLE;
        else        st_q <= st_nxt;
    end

    // count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || (st_q == T_IDLE && start)) begin
            cnt_q <= '0;
        end else if (st_q == T_RUN && !stop && cnt_q != load) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= (st_nxt == T_DONE);
    end

    AST_TMR_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_IDLE && start && !clear) |=> !hit); // R8

    AST_TMR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clear) |=> hit); // R9

    AST_TMR_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_HALT && !clear) |=> $stable(cnt_q)); // R9

    AST_TMR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!hit && cnt_q == '0)); // R10

endmodule

// File: rtl/trig_prim_eval.sv
module trig_prim_eval
    import trig_prim_pkg::*;
#(
    parameter int DW = SMP_W,
    parameter int NM = NUM_MATCH,
    parameter int NR = NUM_RANGE,
    parameter int NE = NUM_EDGE,
    parameter int NT = NUM_TMR,
    parameter int AW = CFG_AW,
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [NT-1:0] tmr_start,
    input  logic [NT-1:0] tmr_stop,
    input  logic [NT-1:0] tmr_clear,
    output logic [NM-1:0] hit_match,
    output logic [NR-1:0] hit_range,
    output logic [NE-1:0] hit_edge,
    output logic [NT-1:0] hit_timer
);

    logic [NM-1:0][DW-1:0]   tgt;
    logic [NM-1:0][DW-1:0]   msk;
    logic [NR-1:0][DW-1:0]   lo;
    logic [NR-1:0][DW-1:0]   hi;
    logic [NE-1:0][2*DW-1:0] ecode;
    logic [NT-1:0][TW-1:0]   load;

    trig_cfg_regs #(
        .DW(DW), .NM(NM), .NR(NR), .NE(NE), .NT(NT), .AW(AW), .TW(TW)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .tgt      (tgt),
        .msk      (msk),
        .lo       (lo),
        .hi       (hi),
        .ecode    (ecode),
        .load     (load)
    );

    trig_cmp_bank #(.DW(DW), .NM(NM), .NR(NR)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .tgt      (tgt),
        .msk      (msk),
        .lo       (lo),
        .hi       (hi),
        .hit_match(hit_match),
        .hit_range(hit_range)
    );

    trig_edge_bank #(.DW(DW), .NE(NE)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .ecode    (ecode),
        .hit_edge (hit_edge)
    );

    generate
        for (genvar t = 0; t < NT; t++) begin : g_tmr
            trig_timer #(.TW(TW)) u_tmr (
                .clk  (clk),
                .rst_n(rst_n),
                .load (load[t]),
                .start(tmr_start[t]),
                .stop (tmr_stop[t]),
                .clear(tmr_clear[t]),
                .hit  (hit_timer[t])
            );
        end
    endgenerate

    AST_CFG_BEFORE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_we && cfg_addr == AW'(ADR_MSK) && msk[0] == '0) |=> hit_match[0]); // R12

endmodule

// File: tb/sim_trig_prim_eval.sv
module sim_trig_prim_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  tmr_start = '0;
    logic [1:0]  tmr_stop = '0;
    logic [1:0]  tmr_clear = '0;
    logic [9:0]  hit_match;
    logic [1:0]  hit_range;
    logic [1:0]  hit_edge;
    logic [1:0]  hit_timer;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    trig_prim_eval u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tmr_start(tmr_start), .tmr_stop(tmr_stop), .tmr_clear(tmr_clear),
        .hit_match(hit_match), .hit_range(hit_range), .hit_edge(hit_edge),
        .hit_timer(hit_timer)
    );

    // reference configuration and state
    logic [31:0] m_tgt [10];
    logic [31:0] m_msk [10];
    logic [31:0] m_lo  [2];
    logic [31:0] m_hi  [2];
    logic [63:0] m_ec  [2];
    logic [31:0] m_prev = '0;
    bit          m_pv = 0;
    logic [9:0]  exp_m = '0;
    logic [1:0]  exp_r = '0;
    logic [1:0]  exp_e = '0;

    function automatic logic f_match(logic [31:0] d, logic [31:0] t, logic [31:0] m);
        return ((d ^ t) & m) == 32'd0;
    endfunction

    function automatic logic f_range(logic [31:0] d, logic [31:0] l, logic [31:0] h);
        return (d >= l) && (d <= h);
    endfunction

    function automatic logic f_edge(logic [31:0] d, logic [31:0] p, bit pv, logic [63:0] code);
        logic res = 1'b0;
        if (!pv) return 1'b0;
        for (int c = 0; c < 32; c++) begin
            if (code[2*c]   && d[c] && !p[c]) res = 1'b1;
            if (code[2*c+1] && !d[c] && p[c]) res = 1'b1;
        end
        return res;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic step(input bit v, input logic [31:0] d, input bit we,
                        input logic [5:0] a, input logic [31:0] w,
                        input logic [1:0] st, input logic [1:0] sp, input logic [1:0] cl);
        smp_valid = v; smp_data = d; cfg_we = we; cfg_addr = a; cfg_wdata = w;
        tmr_start = st; tmr_stop = sp; tmr_clear = cl;
        if (v) begin
            for (int k = 0; k < 10; k++) exp_m[k] = f_match(d, m_tgt[k], m_msk[k]);
            for (int r = 0; r < 2; r++)  exp_r[r] = f_range(d, m_lo[r], m_hi[r]);
            for (int e = 0; e < 2; e++)  exp_e[e] = f_edge(d, m_prev, m_pv, m_ec[e]);
            m_prev = d; m_pv = 1;
        end
        @(posedge clk);
        @(negedge clk);
        if (we) begin
            if (a < 6'd10) m_tgt[a] = w;
            else if (a >= 6'd16 && a < 6'd26) m_msk[a-16] = w;
            else if (a == 6'd32 || a == 6'd33) m_lo[a-32] = w;
            else if (a == 6'd34 || a == 6'd35) m_hi[a-34] = w;
            else if (a >= 6'd36 && a < 6'd40) begin
                if (a[0]) m_ec[(a-36)>>1][63:32] = w;
                else      m_ec[(a-36)>>1][31:0]  = w;
            end
        end
        smp_valid = 0; cfg_we = 0; tmr_start = 0; tmr_stop = 0; tmr_clear = 0;
    endtask

    task automatic smp(input logic [31:0] d);
        step(1, d, 0, 6'd0, 32'd0, 2'b00, 2'b00, 2'b00);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] w);
        step(0, 32'd0, 1, a, w, 2'b00, 2'b00, 2'b00);
    endtask

    task automatic tmr(input logic [1:0] st, input logic [1:0] sp, input logic [1:0] cl);
        step(0, 32'd0, 0, 6'd0, 32'd0, st, sp, cl);
    endtask

    task automatic check_cmp(input string tag);
        chk({tag, " R1/R2 match"}, {22'd0, hit_match}, {22'd0, exp_m});
        chk({tag, " R3 range"},    {30'd0, hit_range}, {30'd0, exp_r});
        chk({tag, " R4/R5 edge"},  {30'd0, hit_edge},  {30'd0, exp_e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] hm;
        void'($urandom(32'h0005_EED5));
        for (int k = 0; k < 10; k++) begin m_tgt[k] = '0; m_msk[k] = '0; end
        for (int r = 0; r < 2; r++) begin m_lo[r] = '0; m_hi[r] = '0; m_ec[r] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset outputs", {16'd0, hit_match, hit_range, hit_edge, hit_timer}, 32'd0);

        // directed configuration
        wr(6'd0,  32'h1234_5678); wr(6'd16, 32'hFFFF_FFFF);
        wr(6'd2,  32'hA5A5_0000); wr(6'd18, 32'hFFFF_0000);
        wr(6'd32, 32'h0000_0100); wr(6'd34, 32'h0000_01FF);
        wr(6'd33, 32'h8000_0000); wr(6'd35, 32'h0000_0010);
        wr(6'd36, 32'hFFFF_FFFF); wr(6'd37, 32'hFFFF_FFFF);
        wr(6'd38, 32'h0000_0400); wr(6'd39, 32'h0000_0000);  // channel 5 rising only
        wr(6'd50, 32'hFFFF_FFFF);                             // unmapped: ignored

        smp(32'h0000_0100);
        chk("R6 first sample no edge", {30'd0, hit_edge}, 32'd0);
        chk("R3 lower bound inclusive", {31'd0, hit_range[0]}, 32'd1);
        chk("R1 zero mask matches", {31'd0, hit_match[1]}, 32'd1);
        chk("R2 unmapped write ignored", {31'd0, hit_match[3]}, 32'd1);
        check_cmp("dir0");
        smp(32'h0000_01FF);
        chk("R3 upper bound inclusive", {31'd0, hit_range[0]}, 32'd1);
        chk("R5 channel5 rise", {31'd0, hit_edge[1]}, 32'd1);
        check_cmp("dir1");
        smp(32'h0000_0200);
        chk("R3 upper+1 excluded", {31'd0, hit_range[0]}, 32'd0);
        chk("R4 fall with rise code", {31'd0, hit_edge[1]}, 32'd0);
        check_cmp("dir2");
        smp(32'h0000_00FF);
        chk("R3 lower-1 excluded", {31'd0, hit_range[0]}, 32'd0);
        check_cmp("dir3");
        smp(32'h0000_00BF);
        chk("R5 dont-care channel6", {31'd0, hit_edge[1]}, 32'd0);
        chk("R4 either edge fall", {31'd0, hit_edge[0]}, 32'd1);
        smp(32'h0000_00BF);
        chk("R4 no change no edge", {30'd0, hit_edge}, 32'd0);
        smp(32'h1234_5678);
        chk("R1 exact match", {31'd0, hit_match[0]}, 32'd1);
        smp(32'h1234_5679);
        chk("R1 one bit off", {31'd0, hit_match[0]}, 32'd0);
        smp(32'hA5A5_FFFF);
        chk("R2 term2 masked match", {31'd0, hit_match[2]}, 32'd1);
        chk("R2 term0 independent", {31'd0, hit_match[0]}, 32'd0);
        smp(32'h8000_0000);
        chk("R3 lower>upper never", {31'd0, hit_range[1]}, 32'd0);
        wr(6'd33, 32'h0000_0000); wr(6'd35, 32'hFFFF_FFFF);
        smp(32'hFFFF_FFFF);
        chk("R3 full range top", {31'd0, hit_range[1]}, 32'd1);
        smp(32'h0000_0000);
        chk("R3 full range bottom", {31'd0, hit_range[1]}, 32'd1);
        hm = hit_match;
        step(0, 32'hFFFF_FFFF, 0, 6'd0, 32'd0, 2'b00, 2'b00, 2'b00);
        chk("R7 hold without valid", {22'd0, hit_match}, {22'd0, hm});
        smp(32'h0000_0000);
        chk("R7 idle data not stored", {30'd0, hit_edge}, 32'd0);
        step(1, 32'h1234_5678, 1, 6'd0, 32'h0000_0000, 2'b00, 2'b00, 2'b00);
        chk("R12 old target used", {31'd0, hit_match[0]}, 32'd1);
        smp(32'h1234_5678);
        chk("R12 new target after", {31'd0, hit_match[0]}, 32'd0);
        smp(32'h0000_0000);
        chk("R12 new target matches", {31'd0, hit_match[0]}, 32'd1);
        check_cmp("dir4");

        // constrained random phase
        for (int i = 0; i < 400; i++) begin
            logic [31:0] d;
            logic [5:0]  a;
            logic [31:0] w;
            int sel;
            bit v, we;
            sel = int'($urandom % 4);
            case (sel)
                0: d = $urandom;
                1: d = m_tgt[$urandom % 10] ^ (32'd1 << ($urandom % 32)) ^ (($urandom % 2) ? 32'd0 : 32'h8000_0000);
                2: d = m_tgt[$urandom % 10];
                default: begin
                    case ($urandom % 4)
                        0: d = m_lo[$urandom % 2];
                        1: d = m_hi[$urandom % 2];
                        2: d = m_lo[$urandom % 2] - 32'd1;
                        default: d = m_hi[$urandom % 2] + 32'd1;
                    endcase
                end
            endcase
            v  = ($urandom % 8) != 0;
            we = ($urandom % 4) == 0;
            a  = 6'($urandom % 48);
            w  = (a >= 6'd16 && a < 6'd26) ? ($urandom & $urandom) : $urandom;
            step(v, d, we, a, w, 2'b00, 2'b00, 2'b00);
            check_cmp("rand R7/R12");
        end

        // timers
        wr(6'd40, 32'd5);
        wr(6'd41, 32'd0);
        tmr(2'b01, 2'b00, 2'b00);
        for (int i = 2; i <= 7; i++) begin
            tmr(2'b00, 2'b00, 2'b00);
            chk("R8 timer0 expiry at L+1", {31'd0, hit_timer[0]}, (i == 7) ? 32'd1 : 32'd0);
        end
        chk("R8 timer1 untouched", {31'd0, hit_timer[1]}, 32'd0);
        repeat (10) tmr(2'b00, 2'b00, 2'b00);
        chk("R9 timer0 holds", {31'd0, hit_timer[0]}, 32'd1);
        tmr(2'b01, 2'b01, 2'b00);
        chk("R9 start/stop in done ignored", {31'd0, hit_timer[0]}, 32'd1);
        tmr(2'b00, 2'b00, 2'b01);
        chk("R10 clear drops output", {31'd0, hit_timer[0]}, 32'd0);
        tmr(2'b01, 2'b00, 2'b01);
        for (int i = 0; i < 9; i++) begin
            tmr(2'b00, 2'b00, 2'b00);
            chk("R10 clear beats start", {31'd0, hit_timer[0]}, 32'd0);
        end
        // pause and resume
        tmr(2'b01, 2'b00, 2'b00);
        tmr(2'b00, 2'b00, 2'b00);
        tmr(2'b00, 2'b00, 2'b00);
        tmr(2'b00, 2'b01, 2'b00);
        for (int i = 0; i < 5; i++) begin
            tmr(2'b00, 2'b00, 2'b00);
            chk("R9 paused no expiry", {31'd0, hit_timer[0]}, 32'd0);
        end
        tmr(2'b01, 2'b01, 2'b00);
        chk("R9 stop beats start", {31'd0, hit_timer[0]}, 32'd0);
        tmr(2'b01, 2'b00, 2'b00);
        for (int i = 11; i <= 14; i++) begin
            tmr(2'b00, 2'b00, 2'b00);
            chk("R9 resume keeps count", {31'd0, hit_timer[0]}, (i == 14) ? 32'd1 : 32'd0);
        end
        // zero reload on timer1
        tmr(2'b10, 2'b00, 2'b01);
        chk("R8 timer1 not yet", {31'd0, hit_timer[1]}, 32'd0);
        chk("R10 timer0 cleared", {31'd0, hit_timer[0]}, 32'd0);
        tmr(2'b00, 2'b00, 2'b00);
        chk("R8 timer1 zero reload", {31'd0, hit_timer[1]}, 32'd1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule